// File: doc/BRIEF.md
# Three-Level Prioritized Interrupt Controller

This block gathers interrupt events from on-chip peripherals and from general-purpose input pins into one pending register, one bit per source. A bit stays set until the CPU accepts that source's vector or software overwrites the pending register. Each source carries two enable bits, a high bit and a low bit, which together either disable it or place it on one of three priority levels. Within a level, the source with the lower index wins. Each source index maps to a two-byte vector slot, so each step in index moves the vector address by two.

A master enable gates only the vectored request toward the CPU. The pending register keeps collecting events whatever the master enable holds, so software can poll it at any time. The vectored request uses a valid/ready handshake. `irq_valid` is high while the master enable is on and at least one pending source is enabled. `irq_vector` and `irq_level` describe the current winner. They may change while the request waits, for example when a higher-priority source arrives, because the request is a live view of the pending register and not a queued item. A transfer happens on a clock edge where `irq_valid` and `irq_ready` are both high. That transfer clears the winner's pending bit. `irq_ready` without `irq_valid` has no effect.

Pin inputs pass through an edge detector. A per-pin select picks rising or falling edges. A pin level must be held for at least two clock edges to be seen.

Top module: `pic_ctrl`

## Requirements
- R1: While `rst_n` is low, `pend` is all zero, `irq_valid` is 0 and `irq_level` is 0. All enables, edge selects and the master enable reset to 0.
- R2: A 1 on `int_evt[k]` at a clock edge sets `pend[k]` at that edge. The bit then stays set until it is cleared by R9 or R10.
- R3: Pin `p` maps to source `NUM_INT+p`. Its edge select is bit `NUM_INT+p` of the edge-select register: 1 selects rising edges and 0 selects falling edges. After the pin changes, the matching pending bit is set at the second clock edge. A change in the other direction is ignored.
- R4: The enable pair {high bit, low bit} of a source gives its level: 00 is disabled, 01 is level 1, 10 is level 2 and 11 is level 3. A disabled pending source is never presented. `irq_level` reports the level of the presented source.
- R5: A pending source at a higher level wins over any source at a lower level, whatever their indices.
- R6: Among pending sources at the same level, the lowest index wins.
- R7: `irq_vector` = `VEC_BASE` + 2 × index. With the defaults (24 sources, base 0x0008), source 0 gives 0x0008 and source 23 gives 0x0036.
- R8: `irq_valid` is high exactly when the master enable is 1 and an enabled source is pending. While the master enable is 0, events still set `pend`.
- R9: A clock edge with `irq_valid` and `irq_ready` both high clears the winner's pending bit and no other bit. Each accepted vector follows R5 and R6.
- R10: A write to the pending register loads `reg_wdata`. If a hardware event sets a bit in the same cycle, that bit ends up 1, even when the write would clear it.
- R11: While `irq_valid` is high and `irq_ready` is low, no pending bit is cleared, and the vector follows the current winner. `irq_ready` without `irq_valid` changes nothing.
- R12: `reg_sel` selects the target of a write when `reg_we` is 1: 0 is the pending register, 1 is the high enable bits, 2 is the low enable bits, 3 is the edge selects, and 4 is the master enable (`reg_wdata[0]`). A write to one target leaves the others unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| int_evt | input | NUM_INT | Peripheral event pulses, one per internal source |
| pin_in | input | NUM_PIN | Raw general-purpose pin levels |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register write target (see R12) |
| reg_wdata | input | NUM_INT+NUM_PIN | Register write data, bit i belongs to source i |
| pend | output | NUM_INT+NUM_PIN | Pending register contents, for polling |
| irq_valid | output | 1 | Vectored request toward the CPU |
| irq_ready | input | 1 | CPU accepts the presented vector |
| irq_vector | output | VEC_W | Vector address of the current winner |
| irq_level | output | 2 | Priority level of the current winner, 0 when none |

## Verification
A pending bit that is set or cleared wrongly shows up on `pend` one clock after the event, write or acceptance that caused it. A pin edge that is missed or invented shows up two clocks after the pin change. A fault in the level decode or the tie-break does not always show on `pend`. It shows on `irq_vector` and `irq_level` in the same cycle the pending set changes, and later as a wrong order of accepted vectors. The bench therefore checks every accepted vector against a queue of expected vectors. A stale master enable shows immediately as a wrong `irq_valid`, while `pend` still tracks events.

// File: rtl/pic_pkg.sv
package pic_pkg;
  typedef enum logic [2:0] {
    SEL_REQ  = 3'd0,
    SEL_ENH  = 3'd1,
    SEL_ENL  = 3'd2,
    SEL_EDGE = 3'd3,
    SEL_CTRL = 3'd4
  } pic_sel_e;

  localparam int unsigned PIC_LEVELS = 3;
endpackage

// File: rtl/pic_edge_capture.sv
module pic_edge_capture #(
  parameter int unsigned NUM_PIN = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_PIN-1:0] pin_in,
  input  logic [NUM_PIN-1:0] rise_sel,
  output logic [NUM_PIN-1:0] edge_evt
);
  logic [NUM_PIN-1:0] now_q, old_q;
  logic               primed_q;

  // First sample loads both stages so no edge is seen out of reset.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      now_q    <= '0;
      old_q    <= '0;
      primed_q <= 1'b0;
    end else begin
      now_q    <= pin_in;
      old_q    <= primed_q ? now_q : pin_in;
      primed_q <= 1'b1;
    end
  end

  for (genvar p = 0; p < NUM_PIN; p++) begin : g_pin
    assign edge_evt[p] = primed_q &
                         (rise_sel[p] ? (now_q[p] & ~old_q[p])
                                      : (~now_q[p] & old_q[p]));
  end
endmodule

// File: rtl/pic_first_set.sv
module pic_first_set #(
  parameter int unsigned WIDTH = 24,
  parameter int unsigned IDX_W = 5
) (
  input  logic [WIDTH-1:0] vec,
  output logic             found,
  output logic [IDX_W-1:0] idx
);
  // Scan from the top down so the lowest set index is the one kept.
  always_comb begin
    found = |vec;
    idx   = '0;
    for (int i = WIDTH - 1; i >= 0; i--) begin
      if (vec[i]) idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/pic_req_bank.sv
module pic_req_bank #(
  parameter int unsigned WIDTH = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] set_vec,
  input  logic             sw_we,
  input  logic [WIDTH-1:0] sw_wdata,
  input  logic [WIDTH-1:0] clr_vec,
  output logic [WIDTH-1:0] pend_q
);
  logic [WIDTH-1:0] base, pend_d;

  // Software load first, then the acceptance clear, then hardware sets win.
  always_comb begin
    base   = sw_we ? sw_wdata : pend_q;
    pend_d = (base & ~clr_vec) | set_vec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_d;
  end
endmodule

// File: rtl/pic_ctrl.sv
module pic_ctrl
  import pic_pkg::*;
#(
  parameter int unsigned NUM_INT  = 16,
  parameter int unsigned NUM_PIN  = 8,
  parameter int unsigned VEC_W    = 16,
  parameter int unsigned VEC_BASE = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_INT-1:0]         int_evt,
  input  logic [NUM_PIN-1:0]         pin_in,
  input  logic                       reg_we,
  input  logic [2:0]                 reg_sel,
  input  logic [NUM_INT+NUM_PIN-1:0] reg_wdata,
  output logic [NUM_INT+NUM_PIN-1:0] pend,
  output logic                       irq_valid,
  input  logic                       irq_ready,
  output logic [VEC_W-1:0]           irq_vector,
  output logic [1:0]                 irq_level
);
  localparam int unsigned NUM_SRC = NUM_INT + NUM_PIN;
  localparam int unsigned IDX_W   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

  pic_sel_e           sel;
  logic [NUM_SRC-1:0] enh_q, enl_q, edge_q;
  logic               mie_q;
  logic [NUM_SRC-1:0] pend_q, set_vec, clr_vec;
  logic [NUM_PIN-1:0] pin_evt;

  assign sel = pic_sel_e'(reg_sel);

  // Configuration registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enh_q  <= '0;
      enl_q  <= '0;
      edge_q <= '0;
      mie_q  <= 1'b0;
    end else if (reg_we) begin
      case (sel)
        SEL_ENH:  enh_q  <= reg_wdata;
        SEL_ENL:  enl_q  <= reg_wdata;
        SEL_EDGE: edge_q <= reg_wdata;
        SEL_CTRL: mie_q  <= reg_wdata[0];
        default:  ;
      endcase
    end
  end

  pic_edge_capture #(.NUM_PIN(NUM_PIN)) u_edges (
    .clk      (clk),
    .rst_n    (rst_n),
    .pin_in   (pin_in),
    .rise_sel (edge_q[NUM_SRC-1:NUM_INT]),
    .edge_evt (pin_evt)
  );

  assign set_vec = {pin_evt, int_evt};

  pic_req_bank #(.WIDTH(NUM_SRC)) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_vec  (set_vec),
    .sw_we    (reg_we && sel == SEL_REQ),
    .sw_wdata (reg_wdata),
    .clr_vec  (clr_vec),
    .pend_q   (pend_q)
  );

  // One lowest-index finder per level, all in parallel
  logic [PIC_LEVELS-1:0] found_l;
  logic [IDX_W-1:0]      idx_l [PIC_LEVELS];

  for (genvar g = 0; g < PIC_LEVELS; g++) begin : g_lvl
    localparam logic [1:0] CODE = 2'(g + 1);
    logic [NUM_SRC-1:0] hit;
    assign hit = pend_q & (CODE[1] ? enh_q : ~enh_q)
                        & (CODE[0] ? enl_q : ~enl_q);
    pic_first_set #(.WIDTH(NUM_SRC), .IDX_W(IDX_W)) u_find (
      .vec   (hit),
      .found (found_l[g]),
      .idx   (idx_l[g])
    );
  end

  logic             win_found;
  logic [IDX_W-1:0] win_idx;
  logic [1:0]       win_lvl;

  // Ascending scan: a higher level overrides a lower one
  always_comb begin
    win_found = 1'b0;
    win_idx   = '0;
    win_lvl   = 2'd0;
    for (int g = 0; g < PIC_LEVELS; g++) begin
      if (found_l[g]) begin
        win_found = 1'b1;
        win_idx   = idx_l[g];
        win_lvl   = 2'(g + 1);
      end
    end
  end

  logic accept;
  assign irq_valid  = mie_q & win_found;
  assign accept     = irq_valid & irq_ready;
  assign clr_vec    = accept ? (NUM_SRC'(1) << win_idx) : '0;
  assign irq_vector = VEC_W'(VEC_BASE) + (VEC_W'(win_idx) << 1);
  assign irq_level  = win_lvl;
  assign pend       = pend_q;
endmodule

// File: rtl/pic_ctrl_chk.sv
module pic_ctrl_chk #(
  parameter int unsigned NUM_INT  = 16,
  parameter int unsigned NUM_PIN  = 8,
  parameter int unsigned VEC_W    = 16,
  parameter int unsigned VEC_BASE = 8
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic [NUM_INT-1:0]         int_evt,
  input logic                       reg_we,
  input logic [2:0]                 reg_sel,
  input logic [NUM_INT+NUM_PIN-1:0] pend,
  input logic                       irq_valid,
  input logic                       irq_ready,
  input logic [VEC_W-1:0]           irq_vector,
  input logic [1:0]                 irq_level,
  input logic [NUM_INT+NUM_PIN-1:0] enh_q,
  input logic [NUM_INT+NUM_PIN-1:0] enl_q,
  input logic [NUM_INT+NUM_PIN-1:0] set_vec,
  input logic                       mie_q
);
  localparam int unsigned NUM_SRC = NUM_INT + NUM_PIN;
  localparam int unsigned IDX_W   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
  localparam logic [VEC_W-1:0] VLO = VEC_W'(VEC_BASE);
  localparam logic [VEC_W-1:0] VHI = VEC_W'(VEC_BASE + 2 * (NUM_SRC - 1));

  logic [VEC_W-1:0] off;
  logic [IDX_W-1:0] idx;
  assign off = irq_vector - VLO;
  assign idx = IDX_W'(off >> 1);

  always @(posedge clk) begin
    if (!rst_n) begin
      assert_reset_quiet_R1: assert (pend == '0 && !irq_valid && irq_level == 2'd0);
    end
  end

  assert_evt_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (int_evt != '0) |=> ((pend[NUM_INT-1:0] & $past(int_evt)) == $past(int_evt)));

  assert_level_match_R4: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> (irq_level != 2'd0 && irq_level == {enh_q[idx], enl_q[idx]} && pend[idx]));

  assert_vec_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> (irq_vector >= VLO && irq_vector <= VHI && irq_vector[0] == 1'b0));

  assert_valid_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> mie_q);

  assert_ack_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid && irq_ready && !set_vec[idx]) |=> !pend[$past(idx)]);

  assert_stall_holds_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!(irq_valid && irq_ready) && !(reg_we && reg_sel == 3'd0))
      |=> ((pend & $past(pend)) == $past(pend)));
endmodule

bind pic_ctrl pic_ctrl_chk #(
  .NUM_INT(NUM_INT), .NUM_PIN(NUM_PIN), .VEC_W(VEC_W), .VEC_BASE(VEC_BASE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .int_evt(int_evt), .reg_we(reg_we), .reg_sel(reg_sel),
  .pend(pend), .irq_valid(irq_valid), .irq_ready(irq_ready),
  .irq_vector(irq_vector), .irq_level(irq_level), .enh_q(enh_q), .enl_q(enl_q),
  .set_vec(set_vec), .mie_q(mie_q)
);

// File: tb/test_pic_ctrl.sv
module test_pic_ctrl;
  localparam int NI = 16;
  localparam int NP = 8;
  localparam int NS = NI + NP;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NI-1:0] int_evt = '0;
  logic [NP-1:0] pin_in = '0;
  logic          reg_we = 1'b0;
  logic [2:0]    reg_sel = '0;
  logic [NS-1:0] reg_wdata = '0;
  logic [NS-1:0] pend;
  logic          irq_valid;
  logic          irq_ready = 1'b0;
  logic [15:0]   irq_vector;
  logic [1:0]    irq_level;

  pic_ctrl i_pic_ctrl (
    .clk(clk), .rst_n(rst_n), .int_evt(int_evt), .pin_in(pin_in),
    .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata), .pend(pend),
    .irq_valid(irq_valid), .irq_ready(irq_ready), .irq_vector(irq_vector),
    .irq_level(irq_level)
  );

  always #10 clk = ~clk;

  int n_cmp = 0;
  int n_bad = 0;
  logic [15:0] exp_q[$];
  string       tag_q[$];
  logic [NS-1:0] enh_m = '0;
  logic [NS-1:0] enl_m = '0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] sel, input logic [NS-1:0] data);
    reg_we = 1'b1; reg_sel = sel; reg_wdata = data;
    tick();
    reg_we = 1'b0;
  endtask

  task automatic evt(input logic [NI-1:0] m);
    int_evt = m;
    tick();
    int_evt = '0;
  endtask

  task automatic push(input logic [15:0] v, input string tag);
    exp_q.push_back(v);
    tag_q.push_back(tag);
  endtask

  task automatic accept(input int n);
    irq_ready = 1'b1;
    repeat (n) tick();
    irq_ready = 1'b0;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  // Monitor: every accepted vector is compared with the scoreboard queue
  always @(posedge clk) begin
    if (rst_n && irq_valid && irq_ready) begin
      n_cmp++;
      if (exp_q.size() == 0) begin
        n_bad++;
        $display("FAIL R9 unexpected accept actual=%0h expected=none", irq_vector);
      end else begin
        logic [15:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (irq_vector !== e) begin
          n_bad++;
          $display("FAIL %s accept order actual=%0h expected=%0h", t, irq_vector, e);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    repeat (3) tick();
    chk("R1 pend in reset", 32'(pend), 0);
    chk("R1 valid in reset", 32'(irq_valid), 0);
    chk("R1 level in reset", 32'(irq_level), 0);
    rst_n = 1'b1;
    tick();

    // Polled collection, then level ordering across levels (R5)
    evt(NI'((1 << 3) | (1 << 9)));
    chk("R2 pend after events", 32'(pend), 32'h208);
    enh_m[9] = 1'b1; enl_m[9] = 1'b1; enl_m[3] = 1'b1;
    wr(3'd1, enh_m);
    chk("R12 pend unchanged by enable write", 32'(pend), 32'h208);
    wr(3'd2, enl_m);
    chk("R8 no request with master off", 32'(irq_valid), 0);
    wr(3'd4, NS'(1));
    chk("R8 request with master on", 32'(irq_valid), 1);
    chk("R5 level 3 beats lower index", 32'(irq_vector), 32'h1A);
    chk("R4 level reported", 32'(irq_level), 3);
    push(16'h1A, "R5"); push(16'h0E, "R9");
    accept(2);
    chk("R9 all cleared", 32'(pend), 0);
    chk("R9 idle after accepts", 32'(irq_valid), 0);

    // Same-level tie break (R6)
    enh_m[2] = 1'b1; enh_m[5] = 1'b1;
    wr(3'd1, enh_m);
    evt(NI'((1 << 2) | (1 << 5) | (1 << 3)));
    chk("R6 lowest index in level", 32'(irq_vector), 32'h0C);
    chk("R4 level 2 reported", 32'(irq_level), 2);
    push(16'h0C, "R6"); push(16'h12, "R6"); push(16'h0E, "R5");
    accept(3);
    chk("R9 cleared after three", 32'(pend), 0);

    // Disabled source (R4), software clear (R10)
    evt(NI'(1 << 7));
    chk("R4 disabled still pending", 32'(pend), 32'h80);
    chk("R4 disabled not presented", 32'(irq_valid), 0);
    wr(3'd0, '0);
    chk("R10 software clear", 32'(pend), 0);

    // Stall behaviour (R11)
    evt(NI'(1 << 2));
    repeat (3) tick();
    chk("R11 held while stalled", 32'(pend), 32'h4);
    chk("R11 vector while stalled", 32'(irq_vector), 32'h0C);
    evt(NI'(1 << 9));
    chk("R11 vector follows new winner", 32'(irq_vector), 32'h1A);
    push(16'h1A, "R11"); push(16'h0C, "R11");
    accept(2);
    chk("R11 drained", 32'(pend), 0);

    // Collision of software write and hardware event (R10)
    reg_we = 1'b1; reg_sel = 3'd0; reg_wdata = NS'(1 << 6); int_evt = NI'(1 << 4);
    tick();
    reg_we = 1'b0; int_evt = '0;
    chk("R10 write plus event", 32'(pend), 32'h50);
    reg_we = 1'b1; reg_sel = 3'd0; reg_wdata = '0; int_evt = NI'(1 << 4);
    tick();
    reg_we = 1'b0; int_evt = '0;
    chk("R10 event wins over clear", 32'(pend), 32'h10);
    wr(3'd0, '0);

    // Pin edges (R3) and vector range (R7)
    wr(3'd3, NS'((1 << 16) | (1 << 23)));
    enl_m[16] = 1'b1; enh_m[23] = 1'b1; enl_m[23] = 1'b1;
    wr(3'd1, enh_m);
    wr(3'd2, enl_m);
    pin_in = 8'b0000_0011;
    tick();
    chk("R3 not yet after one edge", 32'(pend), 0);
    tick();
    chk("R3 rising caught, falling-select ignored", 32'(pend), 32'h10000);
    chk("R7 vector for source 16", 32'(irq_vector), 32'h28);
    pin_in = 8'b0000_0000;
    tick(); tick();
    chk("R3 falling caught", 32'(pend), 32'h30000);
    pin_in = 8'b1000_0000;
    tick(); tick();
    chk("R7 vector for last source", 32'(irq_vector), 32'h36);
    chk("R4 last source level", 32'(irq_level), 3);
    push(16'h36, "R7"); push(16'h28, "R7");
    accept(2);
    chk("R9 disabled pin bit kept", 32'(pend), 32'h20000);
    wr(3'd0, '0);

    // Master off keeps polling alive (R8)
    evt(NI'(1 << 9));
    wr(3'd4, '0);
    chk("R8 master off gates request", 32'(irq_valid), 0);
    chk("R8 polled bit still set", 32'(pend), 32'h200);
    irq_ready = 1'b1;
    tick();
    irq_ready = 1'b0;
    chk("R11 ready without valid no effect", 32'(pend), 32'h200);
    chk("R9 scoreboard drained", exp_q.size(), 0);

    summary();
    $finish;
  end
endmodule